// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is an on-chip synchronous memory with a 36-bit word split into four 9-bit byte lanes. Its bus can switch from read to write and back on every clock without an idle cycle. Address and control are registered on one rising edge. The matching data beat then occupies the bus cycle that follows the second edge after it, for both directions. Read data is launched after that second edge. Write data is sampled on the third edge, so a read beat and a write beat sit in the same kind of bus cycle.

A load cycle starts a new operation, provided all three chip enables are active. Advance cycles then walk through a four-word burst in linear or interleaved order, and every beat keeps the direction of the load that started the burst. An active-low clock enable freezes the whole pipeline. Per-lane write enables mask a write. The tri-state output is modelled as a data word plus a drive-enable, and an asynchronous output enable can force that drive-enable off. A synchronous reset clears the pipeline but leaves the stored words alone.

Top module: `zbt_sram`

## Requirements
- R1: A read issued on an active edge k launches the stored word on `rdata` with `rdata_oe` high after active edge k+2. The word stays there until active edge k+3.
- R2: A write issued on active edge k stores the `wdata` value sampled on active edge k+3. Reads and writes may alternate on every edge with no idle cycle. The drive-enable is low in the data cycle of a write.
- R3: `byte_we_n[i]` is active low. It is captured with the address, and it gates lane i, which is bits [9i+8:9i]. A disabled lane keeps its old contents.
- R4: While `clk_en_n` is high at an edge, every synchronous input, including `wdata`, is ignored. The pipeline, the burst state, `rdata` and `rdata_oe` all hold.
- R5: A load cycle starts an operation only when `en0_n`=0, `en1`=1 and `en2_n`=0. Any other combination is a deselect: it starts nothing and ends any burst. Operations already in flight still complete, and the drive-enable is low in the deselect's data cycle.
- R6: With `order_ilv`=0, beat j of a burst uses address bits [1:0] equal to (start+j) mod 4. The upper bits stay fixed, and the sequence repeats after four beats.
- R7: With `order_ilv`=1, beat j uses address bits [1:0] equal to start XOR (j mod 4).
- R8: An advance cycle (`load_n`=1) repeats the direction of the load that opened the burst. It takes its byte enables from its own cycle. An advance with no burst open does nothing.
- R9: While `oe_n` is high, `rdata_oe` is low at once, regardless of the clock.
- R10: A read issued on the edge after a write to the same address returns the newly written lanes merged with the old ones.
- R11: A synchronous reset (`rst` high) clears the drive-enable, the pipeline and the burst state. The memory contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock enable, active low |
| load_n | input | 1 | 0: load new address, 1: advance burst |
| rw | input | 1 | 1: read, 0: write (used on load cycles) |
| en0_n | input | 1 | Chip enable, active low |
| en1 | input | 1 | Chip enable, active high |
| en2_n | input | 1 | Chip enable, active low |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address |
| byte_we_n | input | 4 | Per-lane write enables, active low |
| wdata | input | 36 | Write data, sampled in the data cycle |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 36 | Read data |
| rdata_oe | output | 1 | Output drive-enable |

## Verification
The bench fills every address, reads each one back, and then alternates writes and reads on consecutive edges. Same-address pairs exercise the bypass path, and different-address pairs show that neighbouring words are untouched. A sweep of all sixteen lane-enable patterns separates each lane's gating. Bursts run from every start offset in both orders and continue past four beats, which tells wrap-around and XOR ordering apart from plain counting. Deselects of every enable combination, stalls placed inside both read and write data cycles, output-enable probes and a mid-run reset show which inputs are ignored and which state is held.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;
  localparam int BEAT_W = 2;

  typedef struct packed {
    logic             vld;
    logic             wr;
    logic [LANES-1:0] be_n;
  } ctl_t;

  // low address bits of a burst beat: linear count or XOR sequence
  function automatic logic [BEAT_W-1:0] burst_lo(input logic [BEAT_W-1:0] start,
                                                 input logic [BEAT_W-1:0] cnt,
                                                 input logic              ilv);
    return ilv ? (start ^ cnt) : (start + cnt);
  endfunction

  // all three enables active
  function automatic logic chip_selected(input logic e0_n, input logic e1, input logic e2_n);
    return !e0_n && e1 && !e2_n;
  endfunction
endpackage

// File: rtl/zbt_addr_gen.sv
module zbt_addr_gen
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stall,
  input  logic                 load_n,
  input  logic                 rw,
  input  logic                 sel_ok,
  input  logic                 ilv,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [LANES-1:0]     be_n,
  output ctl_t                 s1_ctl,
  output logic [ADDR_W-1:0]    s1_addr
);
  logic              burst_on;
  logic              burst_wr;
  logic [ADDR_W-1:0] base;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] beat_nx;
  logic              start_op;
  logic              adv_op;

  assign beat_nx  = beat + BEAT_W'(1);
  assign start_op = !load_n && sel_ok;
  assign adv_op   = load_n && burst_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_on <= 1'b0;
      burst_wr <= 1'b0;
      base     <= '0;
      beat     <= '0;
      s1_ctl   <= '0;
      s1_addr  <= '0;
    end else if (!stall) begin
      if (!load_n) begin
        burst_on <= sel_ok;
        burst_wr <= !rw;
        base     <= addr;
        beat     <= '0;
      end else if (burst_on) begin
        beat <= beat_nx;
      end
      s1_ctl.vld  <= start_op || adv_op;
      s1_ctl.wr   <= load_n ? burst_wr : !rw;
      s1_ctl.be_n <= be_n;
      s1_addr     <= load_n ? {base[ADDR_W-1:BEAT_W], burst_lo(base[BEAT_W-1:0], beat_nx, ilv)}
                            : addr;
    end
  end
endmodule

// File: rtl/zbt_pipe.sv
module zbt_pipe
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  ctl_t              in_ctl,
  input  logic [ADDR_W-1:0] in_addr,
  output ctl_t              rd_ctl,
  output logic [ADDR_W-1:0] rd_addr,
  output ctl_t              wr_ctl,
  output logic [ADDR_W-1:0] wr_addr
);
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    ctl_t              q_ctl;
    logic [ADDR_W-1:0] q_adr;
    ctl_t              d_ctl;
    logic [ADDR_W-1:0] d_adr;
    if (g == 0) begin : g_head
      assign d_ctl = in_ctl;
      assign d_adr = in_addr;
    end else begin : g_link
      assign d_ctl = g_stage[g-1].q_ctl;
      assign d_adr = g_stage[g-1].q_adr;
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        q_ctl <= '0;
        q_adr <= '0;
      end else if (!stall) begin
        q_ctl <= d_ctl;
        q_adr <= d_adr;
      end
    end
  end

  assign rd_ctl  = g_stage[0].q_ctl;
  assign rd_addr = g_stage[0].q_adr;
  assign wr_ctl  = g_stage[STAGES-1].q_ctl;
  assign wr_addr = g_stage[STAGES-1].q_adr;
endmodule

// File: rtl/zbt_array.sv
module zbt_array
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANES-1:0]  wbe_n,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rword
);
  logic same_addr;
  assign same_addr = we && (waddr == raddr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];
    logic              lane_we;
    assign lane_we = we && !wbe_n[g];

    always_ff @(posedge clk) begin
      if (lane_we) lane_mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    // bypass: the write committing on this edge wins over the stored lane
    assign rword[g*LANE_W +: LANE_W] = (same_addr && !wbe_n[g]) ? wdata[g*LANE_W +: LANE_W]
                                                               : lane_mem[raddr];
  end
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en_n,
  input  logic              load_n,
  input  logic              rw,
  input  logic              en0_n,
  input  logic              en1,
  input  logic              en2_n,
  input  logic              order_ilv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        byte_we_n,
  input  logic [35:0]       wdata,
  input  logic              oe_n,
  output logic [35:0]       rdata,
  output logic              rdata_oe
);
  ctl_t              s1_ctl, s2_ctl, s3_ctl;
  logic [ADDR_W-1:0] s1_addr, s2_addr, s3_addr;
  logic [WORD_W-1:0] rword;
  logic [WORD_W-1:0] rd_q;
  logic              rd_drive;

  // named events for the checker
  logic stall, sel_ok, s1_vld, s2_vld, s2_wr, rd_fetch, wr_commit;
  assign stall     = clk_en_n;
  assign sel_ok    = chip_selected(en0_n, en1, en2_n);
  assign s1_vld    = s1_ctl.vld;
  assign s2_vld    = s2_ctl.vld;
  assign s2_wr     = s2_ctl.wr;
  assign rd_fetch  = s2_ctl.vld && !s2_ctl.wr;
  assign wr_commit = s3_ctl.vld && s3_ctl.wr && !stall && !rst;

  zbt_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
    .clk(clk), .rst(rst), .stall(stall), .load_n(load_n), .rw(rw),
    .sel_ok(sel_ok), .ilv(order_ilv), .addr(addr), .be_n(byte_we_n),
    .s1_ctl(s1_ctl), .s1_addr(s1_addr)
  );

  zbt_pipe #(.ADDR_W(ADDR_W), .STAGES(2)) u_pipe (
    .clk(clk), .rst(rst), .stall(stall), .in_ctl(s1_ctl), .in_addr(s1_addr),
    .rd_ctl(s2_ctl), .rd_addr(s2_addr), .wr_ctl(s3_ctl), .wr_addr(s3_addr)
  );

  zbt_array #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(wr_commit), .waddr(s3_addr), .wbe_n(s3_ctl.be_n),
    .wdata(wdata), .raddr(s2_addr), .rword(rword)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_drive <= 1'b0;
    end else if (!stall) begin
      rd_drive <= rd_fetch;
      if (rd_fetch) rd_q <= rword;
    end
  end

  assign rdata    = rd_q;
  assign rdata_oe = rd_drive && !oe_n;
endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk (
  input logic clk,
  input logic rst,
  input logic stall,
  input logic load_n,
  input logic sel_ok,
  input logic oe_n,
  input logic s1_vld,
  input logic s2_vld,
  input logic s2_wr,
  input logic rd_drive,
  input logic rdata_oe
);
  p_stall_hold_r4: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(rd_drive) && $stable(s1_vld) && $stable(s2_vld)));

  p_read_drive_r1: assert property (@(posedge clk) disable iff (rst)
    (!stall && s2_vld && !s2_wr) |=> rd_drive);

  p_write_release_r2: assert property (@(posedge clk) disable iff (rst)
    (!stall && s2_vld && s2_wr) |=> !rd_drive);

  p_pipe_advance_r1: assert property (@(posedge clk) disable iff (rst)
    (!stall && s1_vld) |=> s2_vld);

  p_deselect_r5: assert property (@(posedge clk) disable iff (rst)
    (!stall && !load_n && !sel_ok) |=> !s1_vld);

  p_oe_force_r9: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !rdata_oe);

  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (!rd_drive && !s1_vld && !s2_vld));
endmodule

bind zbt_sram zbt_sram_chk u_chk (
  .clk(clk), .rst(rst), .stall(stall), .load_n(load_n), .sel_ok(sel_ok),
  .oe_n(oe_n), .s1_vld(s1_vld), .s2_vld(s2_vld), .s2_wr(s2_wr),
  .rd_drive(rd_drive), .rdata_oe(rdata_oe)
);

// File: tb/tb_zbt_sram.sv
module tb_zbt_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DEPTH = 16;
  localparam int HMAX = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1, clk_en_n = 1'b0, load_n = 1'b1, rw = 1'b1;
  logic en0_n = 1'b1, en1 = 1'b0, en2_n = 1'b1, order_ilv = 1'b0, oe_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0] byte_we_n = 4'hF;
  logic [35:0] wdata = '0;
  logic [35:0] rdata;
  logic rdata_oe;

  zbt_sram #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .load_n(load_n), .rw(rw),
    .en0_n(en0_n), .en1(en1), .en2_n(en2_n), .order_ilv(order_ilv), .addr(addr),
    .byte_we_n(byte_we_n), .wdata(wdata), .oe_n(oe_n), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  logic [35:0] ref_mem [DEPTH];
  logic h_vld [HMAX];
  logic h_wr  [HMAX];
  int   h_addr[HMAX];
  logic [3:0] h_be [HMAX];
  string h_tag [HMAX];
  int a = 0, floor_a = 0;
  logic prev_stall = 1'b0, last_oe = 1'b0;
  logic [35:0] last_d = '0;
  logic b_on = 1'b0, b_wr = 1'b0;
  int b_base = 0, b_cnt = 0;
  string cur_tag = "R11";
  logic probe_oe = 1'b0;

  function automatic logic [35:0] wpat(input int m);
    return {4'(m + 3), 32'(m * 32'h9E3779B1) ^ 32'h5A5A1234};
  endfunction

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic sample_outputs();
    int m;
    logic exp_rd;
    if (prev_stall) begin
      chk("R4 drive hold", {35'b0, rdata_oe}, {35'b0, last_oe});
      if (last_oe) chk("R4 data hold", rdata, last_d);
    end else begin
      m = a - 3;
      exp_rd = (m >= floor_a) && h_vld[m] && !h_wr[m];
      chk(m >= floor_a ? h_tag[m] : "R11", {35'b0, rdata_oe}, {35'b0, exp_rd && !oe_n});
      if (exp_rd && !oe_n) chk(h_tag[m], rdata, ref_mem[h_addr[m]]);
    end
    last_oe = rdata_oe;
    last_d  = rdata;
    if (probe_oe && rdata_oe) begin
      oe_n = 1'b1; #1;
      chk("R9 forced off", {35'b0, rdata_oe}, 36'd0);
      oe_n = 1'b0; #1;
      chk("R9 restored", {35'b0, rdata_oe}, 36'd1);
    end
  endtask

  // one clock: sample, resolve in the model, drive, wait for the edge
  task automatic step(input logic cen_n, input logic ld_n, input logic rd,
                      input logic [2:0] cs, input int ad, input logic [3:0] be);
    int m, lo, hi, ea;
    @(negedge clk);
    sample_outputs();
    wdata = 36'hF_0BAD_F00D;
    if (!cen_n) begin
      h_tag[a] = cur_tag;
      h_be[a]  = be;
      if (!ld_n) begin
        h_vld[a] = (cs == 3'b111);
        h_wr[a]  = !rd;
        h_addr[a] = ad;
        b_on = (cs == 3'b111); b_wr = !rd; b_base = ad; b_cnt = 0;
      end else if (b_on) begin
        b_cnt = (b_cnt + 1) % 4;
        lo = b_base % 4; hi = b_base - lo;
        ea = order_ilv ? hi + (lo ^ b_cnt) : hi + ((lo + b_cnt) % 4);
        h_vld[a] = 1'b1; h_wr[a] = b_wr; h_addr[a] = ea;
      end else begin
        h_vld[a] = 1'b0; h_wr[a] = 1'b0; h_addr[a] = 0;
      end
      m = a - 3;
      if (m >= floor_a && h_vld[m] && h_wr[m]) begin
        wdata = wpat(m);
        for (int l = 0; l < 4; l++)
          if (!h_be[m][l]) ref_mem[h_addr[m]][l*9 +: 9] = wpat(m) >> (l*9);
      end
    end
    clk_en_n = cen_n; load_n = ld_n; rw = rd;
    en0_n = !cs[0]; en1 = cs[1]; en2_n = !cs[2];
    addr = AW'(ad); byte_we_n = be;
    @(posedge clk);
    if (!cen_n) a++;
    prev_stall = cen_n;
  endtask

  task automatic op_w(input int ad, input logic [3:0] be); step(0, 0, 0, 3'b111, ad, be); endtask
  task automatic op_r(input int ad); step(0, 0, 1, 3'b111, ad, 4'hF); endtask
  task automatic op_adv(input logic [3:0] be); step(0, 1, 1, 3'b111, 5, be); endtask
  task automatic op_idle(); step(0, 0, 1, 3'b000, 0, 4'hF); endtask
  task automatic op_stall(); step(1, a[0], a[1], 3'(a), a * 7, 4'(a)); endtask

  task automatic do_reset();
    repeat (3) op_idle();
    @(negedge clk);
    sample_outputs();
    rst = 1'b1; load_n = 1'b1; clk_en_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    floor_a = a; b_on = 1'b0; prev_stall = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < HMAX; i++) begin h_vld[i] = 0; h_wr[i] = 0; h_addr[i] = 0; h_be[i] = 4'hF; h_tag[i] = "R11"; end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R11 reset drive", {35'b0, rdata_oe}, 36'd0);

    cur_tag = "R2 fill";
    for (int i = 0; i < DEPTH; i++) op_w(i, 4'h0);
    cur_tag = "R1 read";
    for (int i = 0; i < DEPTH; i++) op_r(i);
    cur_tag = "R10 bypass";
    for (int i = 0; i < DEPTH; i++) begin op_w(i ^ 5, 4'h0); op_r(i ^ 5); end
    cur_tag = "R2 alternate";
    for (int i = 0; i < DEPTH; i++) begin op_r(i); op_w(15 - i, 4'h0); end
    cur_tag = "R3 lanes";
    for (int p = 0; p < 16; p++) begin op_w(3, 4'(p)); op_r(3); op_r(2); end

    for (int ilv = 0; ilv < 2; ilv++) begin
      order_ilv = ilv[0];
      cur_tag = ilv ? "R7 interleaved" : "R6 linear";
      for (int s = 0; s < 4; s++) begin
        op_w(8 + s, 4'h0); op_adv(4'h0); op_adv(4'h0); op_adv(4'(s));
        op_r(8 + s); repeat (6) op_adv(4'hF);
        op_idle();
      end
    end
    order_ilv = 1'b0;

    cur_tag = "R8 advance";
    op_w(6, 4'h0); op_adv(4'h0); op_r(5); op_adv(4'hF); op_adv(4'hF);
    op_idle(); op_adv(4'h0); op_adv(4'hF); op_r(6); op_r(7);

    cur_tag = "R5 select";
    for (int c = 0; c < 7; c++) begin
      op_r(2); step(0, 0, 1, 3'(c), 2, 4'hF); step(0, 0, 0, 3'(c), 2, 4'h0);
      op_adv(4'h0); op_r(2);
    end

    cur_tag = "R4 stall";
    op_r(1); op_stall(); op_stall(); op_r(2); op_stall(); op_adv(4'hF);
    op_w(4, 4'h0); op_idle(); op_stall(); op_stall(); op_stall(); op_idle(); op_r(4);
    op_r(9); op_idle(); op_idle(); op_stall(); op_stall(); op_idle();

    cur_tag = "R9 oe";
    probe_oe = 1'b1;
    op_r(5); op_r(6); repeat (3) op_idle();
    probe_oe = 1'b0;

    cur_tag = "R11 keep";
    do_reset();
    for (int i = 0; i < DEPTH; i++) op_r(i);
    repeat (4) op_idle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule